// File: doc/BRIEF.md
# Remote DMA Byte Port Engine

The engine lets a host move bytes in and out of an on-chip packet buffer through a single data port. The host first loads a 16-bit remote address and a 16-bit remote byte count, one byte at a time. It then reads or writes the data port with an access width of 1, 2 or 4 bytes. Each access touches the buffer at the current address. The address then advances by the access width, and the count drops by the same amount. When the count is used up, a completion flag is raised and may drive an interrupt line through a mask.

The buffer holds two mapped regions: a small low region at addresses 0 to 31, and a packet region set by parameters. Any other address is unmapped. Multi-byte accesses are packed little-endian, so the lowest address sits in the lowest data byte. Address stepping honours a ring: a start page and a stop page bound the receive ring, and the address jumps back to the start page when it lands exactly on the stop page.

Top module: `rdma_byte_port`

## Requirements
- R1: After reset, the address and count are zero, the completion flag, the interrupt and the read data are zero, the start page is PMEM_START/256 and the stop page is (PMEM_START+PMEM_BYTES)/256.
- R2: A register write with reg_sel 0/1 loads the low/high address byte, 2/3 the low/high count byte, 4 the start page, 5 the stop page and 6 the mask. Each byte write leaves the other byte of the same register unchanged.
- R3: A data-port access of legal width N (1, 2 or 4) advances the address by N on the same clock edge.
- R4: When the advanced address equals stop page × 256, the address becomes start page × 256. No other value wraps.
- R5: If the count before an access is at most N, the count becomes 0 and the completion flag sets on that edge. Otherwise the count decreases by N.
- R6: A data-port write while the count is zero changes neither the buffer, the address nor the count. A read while the count is zero still returns data, advances the address and sets the flag.
- R7: Mapped bytes are those below 32 or in [PMEM_START, PMEM_START+PMEM_BYTES). An unmapped byte reads as 0xFF and a write to it is dropped. The check is made per byte.
- R8: 2- and 4-byte accesses clear address bit 0 before use. Byte k of the access uses address base+k and dp_wdata/dp_rdata bits [8k+7:8k]. Bytes beyond the width read as zero. Read data appears on dp_rdata after the clock edge of the access and holds until the next read.
- R9: A command strobe with cmd_stop low, with cmd_dma_rd or cmd_dma_wr high, and with the count zero sets the completion flag. Any other command does not set it.
- R10: A register write with reg_sel 7 and bit 6 of the data set clears the completion flag. A set in the same cycle wins over the clear.
- R11: irq is high exactly when (status AND mask) has any of bits 6:0 set. The completion flag is status bit 6.
- R12: A data-port access whose width is not 1, 2 or 4 reads as zero and does not write the buffer. The address and count stay the same.
- R13: A register write to an address or count byte in the same cycle as a data-port access takes priority for that register. The written byte is loaded, the other byte keeps its value from before the access, and the other register still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register byte select (see R2, R10) |
| reg_wdata | input | 8 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_stop | input | 1 | Command stop bit |
| cmd_dma_rd | input | 1 | Command remote read bit |
| cmd_dma_wr | input | 1 | Command remote write bit |
| dp_valid | input | 1 | Data-port access strobe |
| dp_write | input | 1 | Data-port access is a write |
| dp_width | input | 3 | Access width in bytes |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Data-port read data, registered |
| cur_addr | output | 16 | Current remote address |
| cur_count | output | 16 | Remaining remote byte count |
| done_flag | output | 1 | Completion flag (status bit 6) |
| irq | output | 1 | Masked interrupt |

## Verification
Two things can fall in the same cycle. The completion flag can be set by a draining access or a zero-count command while a status-clear write also arrives. A data-port step can also meet a register byte load of the address or count. The bench provokes both by driving the register write together with the access or command in a single cycle. It judges the set-over-clear rule from done_flag, and the register-priority rule from cur_addr and cur_count right after that edge.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int RDMA_AW = 16;
  localparam int RDMA_CW = 16;
  localparam int DONE_BIT = 6;

  typedef logic [RDMA_AW-1:0] rdma_addr_t;
  typedef logic [RDMA_CW-1:0] rdma_cnt_t;

  typedef enum logic [2:0] {
    SEL_ADDR_LO  = 3'd0,
    SEL_ADDR_HI  = 3'd1,
    SEL_CNT_LO   = 3'd2,
    SEL_CNT_HI   = 3'd3,
    SEL_START_PG = 3'd4,
    SEL_STOP_PG  = 3'd5,
    SEL_MASK     = 3'd6,
    SEL_STAT_CLR = 3'd7
  } rdma_sel_e;

  // legal access widths are 1, 2 and 4 bytes
  function automatic logic width_legal(input logic [2:0] w);
    return (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
  endfunction

  // bytes 2 and 4 wide force bit 0 low
  function automatic rdma_addr_t access_base(input rdma_addr_t a, input logic [2:0] w);
    return (w == 3'd1) ? a : {a[RDMA_AW-1:1], 1'b0};
  endfunction

  // step then fold back to the ring start on an exact stop-page hit
  function automatic rdma_addr_t addr_after(input rdma_addr_t a, input logic [2:0] n,
                                            input logic [7:0] spg, input logic [7:0] epg);
    rdma_addr_t s;
    s = a + rdma_addr_t'(n);
    if (s == {epg, 8'h00}) s = {spg, 8'h00};
    return s;
  endfunction

  function automatic logic count_drains(input rdma_cnt_t c, input logic [2:0] n);
    return c <= rdma_cnt_t'(n);
  endfunction

  function automatic rdma_cnt_t count_after(input rdma_cnt_t c, input logic [2:0] n);
    return count_drains(c, n) ? '0 : c - rdma_cnt_t'(n);
  endfunction

endpackage

// File: rtl/rdma_ptrs.sv
module rdma_ptrs
  import rdma_pkg::*;
#(
  parameter logic [7:0] START_PG_RST = 8'h04,
  parameter logic [7:0] STOP_PG_RST  = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       step_en,
  input  logic [2:0] step_n,
  output rdma_addr_t addr_q,
  output rdma_cnt_t  count_q,
  output logic [7:0] start_pg_q,
  output logic [7:0] stop_pg_q,
  output logic       drain_evt
);

  rdma_addr_t addr_d;
  rdma_cnt_t  count_d;
  logic [7:0] start_pg_d, stop_pg_d;

  assign drain_evt = step_en && count_drains(count_q, step_n);

  always_comb begin
    addr_d     = addr_q;
    count_d    = count_q;
    start_pg_d = start_pg_q;
    stop_pg_d  = stop_pg_q;
    if (step_en) begin
      addr_d  = addr_after(addr_q, step_n, start_pg_q, stop_pg_q);
      count_d = count_after(count_q, step_n);
    end
    // a host byte load overrides the step for the register it targets
    if (reg_wr) begin
      case (reg_sel)
        SEL_ADDR_LO:  addr_d     = {addr_q[15:8], reg_wdata};
        SEL_ADDR_HI:  addr_d     = {reg_wdata, addr_q[7:0]};
        SEL_CNT_LO:   count_d    = {count_q[15:8], reg_wdata};
        SEL_CNT_HI:   count_d    = {reg_wdata, count_q[7:0]};
        SEL_START_PG: start_pg_d = reg_wdata;
        SEL_STOP_PG:  stop_pg_d  = reg_wdata;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      count_q    <= '0;
      start_pg_q <= START_PG_RST;
      stop_pg_q  <= STOP_PG_RST;
    end else begin
      addr_q     <= addr_d;
      count_q    <= count_d;
      start_pg_q <= start_pg_d;
      stop_pg_q  <= stop_pg_d;
    end
  end

endmodule

// File: rtl/rdma_status.sv
module rdma_status
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic [6:0] reg_wdata,
  input  logic       set_evt,
  output logic       flag_q,
  output logic       irq
);

  logic [6:0] mask_q;
  logic [6:0] status;
  logic       clr_evt;

  assign status  = {flag_q, 6'b0};
  assign clr_evt = reg_wr && (reg_sel == SEL_STAT_CLR) && reg_wdata[DONE_BIT];
  assign irq     = |(status & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (reg_wr && (reg_sel == SEL_MASK)) mask_q <= reg_wdata;
    end
  end

endmodule

// File: rtl/rdma_buffer.sv
module rdma_buffer
  import rdma_pkg::*;
#(
  parameter int PROM_BYTES = 32,
  parameter int PMEM_START = 1024,
  parameter int PMEM_BYTES = 1024,
  parameter int LANES      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  rdma_addr_t           base,
  input  logic [2:0]           width,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata
);

  localparam int DEPTH = PROM_BYTES + PMEM_BYTES;
  localparam int IW    = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [LANES-1:0] lane_on;
  logic [LANES-1:0] lane_hit;
  logic [IW-1:0] lane_idx [LANES];
  logic [8*LANES-1:0] lane_rd;

  function automatic logic in_window(input rdma_addr_t a);
    logic [31:0] v;
    v = 32'(a);
    return (v < 32'(PROM_BYTES)) ||
           ((v >= 32'(PMEM_START)) && (v < 32'(PMEM_START + PMEM_BYTES)));
  endfunction

  function automatic logic [IW-1:0] to_index(input rdma_addr_t a);
    logic [31:0] v;
    v = 32'(a);
    if (v < 32'(PROM_BYTES)) return IW'(v);
    return IW'(v - 32'(PMEM_START) + 32'(PROM_BYTES));
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdma_addr_t la;
    assign la          = base + rdma_addr_t'(g);
    assign lane_on[g]  = width_legal(width) && (3'(g) < width);
    assign lane_hit[g] = in_window(la);
    assign lane_idx[g] = lane_hit[g] ? to_index(la) : '0;
    assign lane_rd[8*g +: 8] = !lane_on[g] ? 8'h00 :
                               lane_hit[g] ? mem[lane_idx[g]] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en && lane_on[i] && lane_hit[i]) mem[lane_idx[i]] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= lane_rd;
  end

endmodule

// File: rtl/rdma_byte_port.sv
module rdma_byte_port
  import rdma_pkg::*;
#(
  parameter int PROM_BYTES = 32,
  parameter int PMEM_START = 1024,
  parameter int PMEM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        cmd_valid,
  input  logic        cmd_stop,
  input  logic        cmd_dma_rd,
  input  logic        cmd_dma_wr,
  input  logic        dp_valid,
  input  logic        dp_write,
  input  logic [2:0]  dp_width,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  output logic [15:0] cur_addr,
  output logic [15:0] cur_count,
  output logic        done_flag,
  output logic        irq
);

  localparam logic [7:0] START_PG_RST = 8'(PMEM_START / 256);
  localparam logic [7:0] STOP_PG_RST  = 8'((PMEM_START + PMEM_BYTES) / 256);

  // named internal events, visible to the checker
  logic       width_ok;
  logic       count_zero;
  logic       wr_blocked;
  logic       step_en;
  logic       buf_wr;
  logic       buf_rd;
  logic       drain_evt;
  logic       cmd_hit;
  logic       set_evt;
  rdma_addr_t base_addr;
  logic [7:0] start_pg_q;
  logic [7:0] stop_pg_q;

  assign width_ok   = width_legal(dp_width);
  assign count_zero = (cur_count == '0);
  assign wr_blocked = dp_write && count_zero;
  assign step_en    = dp_valid && width_ok && !wr_blocked;
  assign buf_wr     = step_en && dp_write;
  assign buf_rd     = dp_valid && !dp_write;
  assign base_addr  = access_base(cur_addr, dp_width);
  assign cmd_hit    = cmd_valid && !cmd_stop && (cmd_dma_rd || cmd_dma_wr) && count_zero;
  assign set_evt    = drain_evt || cmd_hit;

  rdma_ptrs #(
    .START_PG_RST(START_PG_RST),
    .STOP_PG_RST (STOP_PG_RST)
  ) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .step_en   (step_en),
    .step_n    (dp_width),
    .addr_q    (cur_addr),
    .count_q   (cur_count),
    .start_pg_q(start_pg_q),
    .stop_pg_q (stop_pg_q),
    .drain_evt (drain_evt)
  );

  rdma_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata[6:0]),
    .set_evt  (set_evt),
    .flag_q   (done_flag),
    .irq      (irq)
  );

  rdma_buffer #(
    .PROM_BYTES(PROM_BYTES),
    .PMEM_START(PMEM_START),
    .PMEM_BYTES(PMEM_BYTES),
    .LANES     (4)
  ) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(buf_rd),
    .wr_en(buf_wr),
    .base (base_addr),
    .width(dp_width),
    .wdata(dp_wdata),
    .rdata(dp_rdata)
  );

endmodule

// File: rtl/rdma_byte_port_chk.sv
module rdma_byte_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dp_valid,
  input logic        dp_write,
  input logic [2:0]  dp_width,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic        clr_bit,
  input logic [15:0] cur_addr,
  input logic [15:0] cur_count,
  input logic        done_flag,
  input logic        irq,
  input logic [7:0]  start_pg,
  input logic        drain_evt,
  input logic        cmd_hit,
  input logic        step_en,
  input logic        width_ok
);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !reg_wr |=>
      (cur_addr == $past(cur_addr) + 16'($past(dp_width))) || (cur_addr == {start_pg, 8'h00}));

  a_r5_drain_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt && !reg_wr |=> done_flag && (cur_count == 16'h0000));

  a_r6_zero_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && dp_write && (cur_count == 16'h0000) && !reg_wr |=>
      $stable(cur_addr) && (cur_count == 16'h0000));

  a_r9_cmd_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> done_flag);

  a_r10_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_sel == 3'd7) && clr_bit && !drain_evt && !cmd_hit |=> !done_flag);

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  a_r12_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid && !width_ok && !reg_wr |=> $stable(cur_addr) && $stable(cur_count));

endmodule

bind rdma_byte_port rdma_byte_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dp_valid (dp_valid),
  .dp_write (dp_write),
  .dp_width (dp_width),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .clr_bit  (reg_wdata[6]),
  .cur_addr (cur_addr),
  .cur_count(cur_count),
  .done_flag(done_flag),
  .irq      (irq),
  .start_pg (start_pg_q),
  .drain_evt(drain_evt),
  .cmd_hit  (cmd_hit),
  .step_en  (step_en),
  .width_ok (width_ok)
);

// File: tb/rdma_byte_port_test.sv
module rdma_byte_port_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        cmd_valid = 1'b0, cmd_stop = 1'b0, cmd_dma_rd = 1'b0, cmd_dma_wr = 1'b0;
  logic        dp_valid = 1'b0, dp_write = 1'b0;
  logic [2:0]  dp_width = '0;
  logic [31:0] dp_wdata = '0;
  logic [31:0] dp_rdata;
  logic [15:0] cur_addr, cur_count;
  logic        done_flag, irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rdma_byte_port uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_stop(cmd_stop), .cmd_dma_rd(cmd_dma_rd), .cmd_dma_wr(cmd_dma_wr),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_width(dp_width), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .cur_addr(cur_addr), .cur_count(cur_count),
    .done_flag(done_flag), .irq(irq)
  );

  // bench-side model of the engine
  logic [15:0] m_addr = '0, m_cnt = '0;
  logic [7:0]  m_spg = 8'h04, m_epg = 8'h08;
  logic [6:0]  m_mask = '0;
  bit          m_flag = 1'b0;
  byte unsigned bm[int];

  logic [31:0] expq[$];
  logic [31:0] exptag[$];
  bit          rd_seen = 1'b0;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 1'b0;

  function automatic bit mapped(input int a);
    return (a < 32) || (a >= 1024 && a < 2048);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: read data is compared one half-cycle after the edge of the read
  always @(posedge clk) rd_seen <= rst_n && dp_valid && !dp_write;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (expq.size() == 0) check("R8", "unexpected read", dp_rdata, 32'hx);
      else check("R8", "read data", dp_rdata, expq.pop_front());
    end
  end

  task automatic run_cycle(input bit dv, input bit dw, input logic [2:0] w, input logic [31:0] wd,
                           input bit rv, input logic [2:0] rs, input logic [7:0] rd,
                           input bit cv, input bit cs, input bit crd, input bit cwr,
                           input string tag);
    logic [15:0] base, na, nc;
    logic [31:0] e;
    bit ok, set, clr;
    ok   = (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
    base = (w == 3'd1) ? m_addr : (m_addr & 16'hFFFE);
    na = m_addr; nc = m_cnt; set = 0; clr = 0;
    if (dv && !dw) begin
      e = '0;
      if (ok) begin
        for (int i = 0; i < int'(w); i++) begin
          int a;
          a = (int'(base) + i) & 32'hFFFF;
          e[8*i +: 8] = mapped(a) ? (bm.exists(a) ? bm[a] : 8'h00) : 8'hFF;
        end
      end
      expq.push_back(e);
    end
    if (dv && ok && !(dw && m_cnt == 16'h0)) begin
      if (dw) begin
        for (int i = 0; i < int'(w); i++) begin
          int a;
          a = (int'(base) + i) & 32'hFFFF;
          if (mapped(a)) bm[a] = wd[8*i +: 8];
        end
      end
      na = m_addr + 16'(w);
      if (na == {m_epg, 8'h00}) na = {m_spg, 8'h00};
      if (m_cnt <= 16'(w)) begin nc = 16'h0; set = 1; end
      else nc = m_cnt - 16'(w);
    end
    if (cv && !cs && (crd || cwr) && m_cnt == 16'h0) set = 1;
    if (rv) begin
      case (rs)
        3'd0: na = {m_addr[15:8], rd};
        3'd1: na = {rd, m_addr[7:0]};
        3'd2: nc = {m_cnt[15:8], rd};
        3'd3: nc = {rd, m_cnt[7:0]};
        3'd4: m_spg = rd;
        3'd5: m_epg = rd;
        3'd6: m_mask = rd[6:0];
        default: clr = rd[6];
      endcase
    end
    m_flag = set ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_addr = na;
    m_cnt  = nc;
    dp_valid = dv; dp_write = dw; dp_width = w; dp_wdata = wd;
    reg_wr = rv; reg_sel = rs; reg_wdata = rd;
    cmd_valid = cv; cmd_stop = cs; cmd_dma_rd = crd; cmd_dma_wr = cwr;
    @(posedge clk);
    @(negedge clk);
    dp_valid = 0; dp_write = 0; reg_wr = 0; cmd_valid = 0;
    check(tag, "cur_addr", 32'(cur_addr), 32'(m_addr));
    check(tag, "cur_count", 32'(cur_count), 32'(m_cnt));
    check(tag, "done_flag", 32'(done_flag), 32'(m_flag));
    check("R11", "irq", 32'(irq), 32'(m_flag && m_mask[6]));
  endtask

  task automatic rw(input logic [2:0] s, input logic [7:0] d, input string tag);
    run_cycle(0, 0, 3'd0, 32'h0, 1, s, d, 0, 0, 0, 0, tag);
  endtask
  task automatic dpw(input logic [2:0] w, input logic [31:0] d, input string tag);
    run_cycle(1, 1, w, d, 0, 3'd0, 8'h0, 0, 0, 0, 0, tag);
  endtask
  task automatic dpr(input logic [2:0] w, input string tag);
    run_cycle(1, 0, w, 32'h0, 0, 3'd0, 8'h0, 0, 0, 0, 0, tag);
  endtask
  task automatic cmd(input bit s, input bit r, input bit wb, input string tag);
    run_cycle(0, 0, 3'd0, 32'h0, 0, 3'd0, 8'h0, 1, s, r, wb, tag);
  endtask
  task automatic set_addr(input logic [15:0] a);
    rw(3'd0, a[7:0], "R2"); rw(3'd1, a[15:8], "R2");
  endtask
  task automatic set_cnt(input logic [15:0] c);
    rw(3'd2, c[7:0], "R2"); rw(3'd3, c[15:8], "R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "reset addr", 32'(cur_addr), 32'h0);
    check("R1", "reset count", 32'(cur_count), 32'h0);
    check("R1", "reset flag", 32'(done_flag), 32'h0);
    check("R1", "reset irq", 32'(irq), 32'h0);
    check("R1", "reset rdata", dp_rdata, 32'h0);

    // R2 byte halves
    rw(3'd0, 8'h34, "R2"); rw(3'd1, 8'h12, "R2"); rw(3'd0, 8'h56, "R2");
    rw(3'd3, 8'h77, "R2"); rw(3'd2, 8'h01, "R2"); rw(3'd3, 8'h00, "R2");

    // R3/R5/R8 write stream
    set_addr(16'h0400); set_cnt(16'd8);
    dpw(3'd4, 32'hDDCCBBAA, "R8");
    dpw(3'd2, 32'h00001234, "R3");
    dpw(3'd1, 32'h00000056, "R3");
    dpw(3'd1, 32'h00000078, "R5");

    // R6 zero-count write ignored, read at zero still steps
    dpw(3'd2, 32'h0000FFFF, "R6");
    rw(3'd7, 8'h40, "R10");
    rw(3'd7, 8'h00, "R10");
    set_addr(16'h0400);
    dpr(3'd4, "R6");

    // R8 read back and packing
    set_cnt(16'h0040); set_addr(16'h0400);
    dpr(3'd4, "R8"); dpr(3'd2, "R8"); dpr(3'd1, "R8"); dpr(3'd1, "R8");
    set_addr(16'h0405); dpr(3'd2, "R8");

    // R7 window
    set_addr(16'h0100); dpr(3'd4, "R7");
    set_addr(16'h0100); dpw(3'd4, 32'h11223344, "R7");
    set_addr(16'h0100); dpr(3'd1, "R7");
    set_addr(16'h03FE); dpr(3'd4, "R7");
    set_addr(16'h001E); dpw(3'd2, 32'h0000BEEF, "R7");
    set_addr(16'h001E); dpr(3'd4, "R7");

    // R4 ring wrap
    set_addr(16'h07FE); dpw(3'd2, 32'h0000CAFE, "R4");
    set_addr(16'h07FC); dpw(3'd2, 32'h00000304, "R4");
    set_addr(16'h07FC); dpr(3'd4, "R4");
    set_addr(16'h07FF); dpr(3'd2, "R4");
    rw(3'd5, 8'h06, "R4"); set_addr(16'h05FE); dpw(3'd2, 32'h00009A9B, "R4");
    rw(3'd5, 8'h08, "R4"); rw(3'd4, 8'h05, "R4");
    set_addr(16'h07FE); dpr(3'd2, "R4");
    rw(3'd4, 8'h04, "R4");

    // R5 count boundaries
    rw(3'd7, 8'h40, "R10");
    set_cnt(16'd3); set_addr(16'h0400); dpr(3'd4, "R5");
    rw(3'd7, 8'h40, "R10");
    set_cnt(16'd5); set_addr(16'h0400); dpr(3'd4, "R5"); dpr(3'd1, "R5");

    // R9 commands
    rw(3'd7, 8'h40, "R10"); set_cnt(16'd0);
    cmd(0, 1, 0, "R9"); rw(3'd7, 8'h40, "R10");
    cmd(0, 0, 1, "R9"); rw(3'd7, 8'h40, "R10");
    cmd(1, 1, 0, "R9"); cmd(0, 0, 0, "R9");
    set_cnt(16'd2); cmd(0, 1, 1, "R9");

    // R11 mask
    rw(3'd6, 8'h40, "R11");
    set_cnt(16'd0); cmd(0, 1, 0, "R11");
    rw(3'd6, 8'h3F, "R11"); rw(3'd6, 8'h40, "R11");
    rw(3'd7, 8'h40, "R11");

    // R12 illegal widths
    set_addr(16'h0400); set_cnt(16'd8);
    dpr(3'd3, "R12"); dpw(3'd3, 32'hFFFFFFFF, "R12"); dpr(3'd0, "R12");
    dpw(3'd7, 32'h0, "R12"); dpr(3'd1, "R12");

    // R13 register load against a step in the same cycle
    set_addr(16'h0410); set_cnt(16'd4);
    run_cycle(1, 1, 3'd2, 32'h0000A1A2, 1, 3'd0, 8'h20, 0, 0, 0, 0, "R13");
    run_cycle(1, 1, 3'd1, 32'h000000A3, 1, 3'd3, 8'h01, 0, 0, 0, 0, "R13");

    // R10 set beats clear
    rw(3'd7, 8'h40, "R10"); set_cnt(16'd1);
    run_cycle(1, 1, 3'd1, 32'h000000A4, 1, 3'd7, 8'h40, 0, 0, 0, 0, "R10");
    run_cycle(0, 0, 3'd0, 32'h0, 1, 3'd7, 8'h40, 1, 0, 0, 1, "R10");

    @(negedge clk); @(negedge clk);
    check("R8", "pending reads", 32'(expq.size()), 32'h0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule